// File: doc/BRIEF.md
# Associative Address Translation Cache with Access Checking

This block keeps a small set of recently used page translations and resolves a virtual address against all of them at once. Pages are 8 KB, so the low 13 address bits are carried straight across and only the upper bits (the virtual page number) are looked up. A lookup that finds its page produces the physical address in the same cycle. A lookup that finds no valid page reports a miss and hands the page number and access kind to whatever services misses. A store aimed at a page whose write permission is clear reports a protection fault and produces no address.

Each slot records whether it was used since it was installed and whether a store went through it. A lookup returns these two flags as they stood before that lookup. After a miss, the handler installs the translation through the fill port. A fill goes to a slot already holding the same page if there is one, then to the lowest empty slot, and otherwise to a slot picked by a rotating pointer. That pointer never lands on the slot that hit most recently. A flush input empties the whole cache in one cycle when the address space changes.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_valid` is high and a valid slot holds the page `lk_addr[31:13]`, and the access is allowed, `lk_hit` is high in the same cycle. `lk_paddr` is then that slot's frame number followed by `lk_addr[12:0]`. `lk_paddr` is zero whenever `lk_hit` is low.
- R2: When `lk_valid` is high and no valid slot holds the page, `lk_miss` is high. `miss_vpn` then equals `lk_addr[31:13]` and `miss_kind` equals `lk_kind`. Both are zero whenever `lk_miss` is low.
- R3: Access kinds are coded 00 read, 01 write, 10 execute, and 11 is handled as a read. A write (01) that matches a slot whose write permission is clear raises `lk_fault` instead of `lk_hit`. Such a fault sets neither the used flag nor the modified flag.
- R4: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high. With `lk_valid` low, all three are low.
- R5: On a hit, `lk_ref` shows the slot's used flag before the hit. The hit then sets that flag. A fill clears it. `lk_ref` is zero when there is no hit.
- R6: On a hit, `lk_dirty` shows the slot's modified flag before the hit. A write hit sets that flag. A fill clears it. `lk_dirty` is zero when there is no hit.
- R7: A fill whose page is already held by a valid slot overwrites that slot, so a page never occupies two slots. Otherwise the fill goes to the lowest-numbered empty slot when one exists.
- R8: When every slot is valid, a fill of a new page evicts the slot under a rotating pointer, which starts at 0 and moves one past each slot it evicts, wrapping from the last slot to 0. If the pointer rests on the slot that hit most recently (counting a hit in the same cycle), the slot after it is evicted instead.
- R9: A high `flush` invalidates every slot at the next clock edge. A fill in the same cycle is discarded, and the used and modified flags and the pointer are left as they were.
- R10: After reset every slot is empty, the pointer is 0 and no slot counts as recently hit.
- R11: A fill takes effect at the clock edge. A lookup in the same cycle as the fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| lk_hit | output | 1 | Translation found and allowed |
| lk_fault | output | 1 | Write to a write-protected page |
| lk_miss | output | 1 | No valid slot holds the page |
| lk_paddr | output | 32 | Physical address on a hit |
| lk_ref | output | 1 | Used flag of the hit slot before this lookup |
| lk_dirty | output | 1 | Modified flag of the hit slot before this lookup |
| miss_vpn | output | 19 | Page number of the missing lookup |
| miss_kind | output | 2 | Access kind of the missing lookup |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 19 | Page number to install |
| fill_pfn | input | 19 | Frame number to install |
| fill_wen | input | 1 | Write permission of the installed page |

## Verification
Directed lookups at offsets 0, 0x1FFF and values in between separate a correct offset pass-through from a wrong frame select. Repeated reads and writes to one page show the used and modified flags rising only on the right kind of access, and a faulting write followed by an execute shows that faults leave the flags alone. Fills of new pages into a full cache are mixed with hits on the slot under the pointer, in the same cycle and one cycle earlier, so the evicted slot reveals whether the pointer skips the most recent hit. A long pseudo-random run over 64 pages, more pages than there are slots, with occasional flushes and fills that coincide with lookups, exercises duplicate overwrites, wrap-around of the pointer and flush priority against a behavioural model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot #(
   parameter int VPN_W = 19,
   parameter int PFN_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             load,
   input  logic [VPN_W-1:0] load_vpn,
   input  logic [PFN_W-1:0] load_pfn,
   input  logic             load_wen,
   input  logic             touch,
   input  logic             mark_dirty,
   input  logic [VPN_W-1:0] probe_vpn,
   output logic             valid_o,
   output logic             match_o,
   output logic             dup_o,
   output logic [PFN_W-1:0] pfn_o,
   output logic             wen_o,
   output logic             ref_o,
   output logic             dirty_o
);
   logic [VPN_W-1:0] vpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         vpn_q   <= '0;
         pfn_o   <= '0;
         wen_o   <= 1'b0;
         ref_o   <= 1'b0;
         dirty_o <= 1'b0;
      end else if (flush) begin
         valid_o <= 1'b0;
      end else if (load) begin
         valid_o <= 1'b1;
         vpn_q   <= load_vpn;
         pfn_o   <= load_pfn;
         wen_o   <= load_wen;
         ref_o   <= 1'b0;
         dirty_o <= 1'b0;
      end else begin
         if (touch)      ref_o   <= 1'b1;
         if (mark_dirty) dirty_o <= 1'b1;
      end
   end

   assign match_o = valid_o && (vpn_q == probe_vpn);
   assign dup_o   = valid_o && (vpn_q == load_vpn);
endmodule

// File: rtl/xlat_onehot_enc.sv
module xlat_onehot_enc #(
   parameter int N  = 48,
   parameter int IW = 6
) (
   input  logic [N-1:0]  vec,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      any_o = |vec;
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) idx_o = idx_o | IW'(i);
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int N  = 48,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [N-1:0]  valid_vec,
   input  logic          hit_any,
   input  logic [IW-1:0] hit_idx,
   input  logic          fill_req,
   input  logic          fill_dup,
   output logic [IW-1:0] slot_o,
   output logic          evict_o
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   logic [IW-1:0] ptr_q, last_q, free_idx, cur_last, rot;
   logic          last_v_q, free_any, cur_last_v;

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_any = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   assign cur_last_v = hit_any | last_v_q;
   assign cur_last   = hit_any ? hit_idx : last_q;
   assign rot        = (cur_last_v && cur_last == ptr_q) ? next_idx(ptr_q) : ptr_q;
   assign slot_o     = free_any ? free_idx : rot;
   assign evict_o    = fill_req && !fill_dup && !free_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         last_q   <= '0;
         last_v_q <= 1'b0;
      end else if (flush) begin
         last_v_q <= 1'b0;
      end else begin
         if (evict_o) ptr_q <= next_idx(rot);
         if (hit_any) begin
            last_v_q <= 1'b1;
            last_q   <= hit_idx;
         end
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int ENTRIES = 48,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFFS_W  = 13,
   localparam int VPN_W  = VA_W - OFFS_W,
   localparam int PFN_W  = PA_W - OFFS_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_addr,
   input  logic [1:0]        lk_kind,
   output logic              lk_hit,
   output logic              lk_fault,
   output logic              lk_miss,
   output logic [PA_W-1:0]   lk_paddr,
   output logic              lk_ref,
   output logic              lk_dirty,
   output logic [VPN_W-1:0]  miss_vpn,
   output logic [1:0]        miss_kind,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              fill_wen
);
   import xlat_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (OFFS_W < 1 || OFFS_W >= VA_W || OFFS_W >= PA_W) begin : g_bad_offs
      $error("xlat_cache: OFFS_W must be below both address widths");
   end

   logic [VPN_W-1:0]  lk_vpn;
   logic              is_write;
   logic [ENTRIES-1:0] valid_vec, hit_vec, dup_vec, wen_vec, ref_vec, dirty_vec;
   logic [PFN_W-1:0]  pfn_arr [ENTRIES];
   logic              probe_any, dup_any, vic_evict, fill_req;
   logic [IDX_W-1:0]  probe_idx, dup_idx, vic_slot, fill_slot;
   logic [PFN_W-1:0]  sel_pfn;
   logic              sel_wen, sel_ref, sel_dirty;

   assign lk_vpn   = lk_addr[VA_W-1:OFFS_W];
   assign is_write = (acc_kind_e'(lk_kind) == ACC_WRITE);
   assign fill_req = fill_valid && !flush;

   xlat_onehot_enc #(.N(ENTRIES), .IW(IDX_W)) u_probe_enc (
      .vec(hit_vec), .any_o(probe_any), .idx_o(probe_idx));

   xlat_onehot_enc #(.N(ENTRIES), .IW(IDX_W)) u_dup_enc (
      .vec(dup_vec), .any_o(dup_any), .idx_o(dup_idx));

   always_comb begin
      sel_pfn   = '0;
      sel_wen   = 1'b0;
      sel_ref   = 1'b0;
      sel_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            sel_pfn   = sel_pfn | pfn_arr[i];
            sel_wen   = sel_wen | wen_vec[i];
            sel_ref   = sel_ref | ref_vec[i];
            sel_dirty = sel_dirty | dirty_vec[i];
         end
      end
   end

   assign lk_fault  = lk_valid && probe_any && is_write && !sel_wen;
   assign lk_hit    = lk_valid && probe_any && !lk_fault;
   assign lk_miss   = lk_valid && !probe_any;
   assign lk_paddr  = lk_hit ? {sel_pfn, lk_addr[OFFS_W-1:0]} : '0;
   assign lk_ref    = lk_hit && sel_ref;
   assign lk_dirty  = lk_hit && sel_dirty;
   assign miss_vpn  = lk_miss ? lk_vpn : '0;
   assign miss_kind = lk_miss ? lk_kind : 2'b00;

   xlat_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .flush(flush), .valid_vec(valid_vec),
      .hit_any(lk_hit), .hit_idx(probe_idx), .fill_req(fill_req),
      .fill_dup(dup_any), .slot_o(vic_slot), .evict_o(vic_evict));

   assign fill_slot = dup_any ? dup_idx : vic_slot;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      xlat_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .load(fill_req && fill_slot == IDX_W'(g)),
         .load_vpn(fill_vpn), .load_pfn(fill_pfn), .load_wen(fill_wen),
         .touch(lk_hit && hit_vec[g]),
         .mark_dirty(lk_hit && is_write && hit_vec[g]),
         .probe_vpn(lk_vpn),
         .valid_o(valid_vec[g]), .match_o(hit_vec[g]), .dup_o(dup_vec[g]),
         .pfn_o(pfn_arr[g]), .wen_o(wen_vec[g]), .ref_o(ref_vec[g]),
         .dirty_o(dirty_vec[g]));
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int ENTRIES = 48,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFFS_W  = 13,
   parameter int IDX_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               lk_valid,
   input logic [VA_W-1:0]    lk_addr,
   input logic [1:0]         lk_kind,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic               lk_miss,
   input logic [PA_W-1:0]    lk_paddr,
   input logic [ENTRIES-1:0] hit_vec,
   input logic               vic_evict,
   input logic [IDX_W-1:0]   vic_slot
);
   logic             seen_v;
   logic [IDX_W-1:0] seen_idx, enc_idx;

   always_comb begin
      enc_idx = '0;
      for (int i = 0; i < ENTRIES; i++) if (hit_vec[i]) enc_idx = IDX_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_v   <= 1'b0;
         seen_idx <= '0;
      end else if (flush) begin
         seen_v <= 1'b0;
      end else if (lk_hit) begin
         seen_v   <= 1'b1;
         seen_idx <= enc_idx;
      end
   end

   assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));
   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFFS_W-1:0] == lk_addr[OFFS_W-1:0]);
   assert_fault_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_kind == 2'b01);
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit && !lk_fault);
   assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   assert_skip_recent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_evict && !lk_hit && seen_v) |-> vic_slot != seen_idx);
   assert_skip_current_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_evict && lk_hit) |-> !((hit_vec >> vic_slot) & 1));
endmodule

bind xlat_cache xlat_cache_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
   .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_fault(lk_fault),
   .lk_miss(lk_miss), .lk_paddr(lk_paddr), .hit_vec(hit_vec),
   .vic_evict(vic_evict), .vic_slot(vic_slot)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
   localparam int N = 48;
   localparam int VW = 19;
   localparam int PW = 19;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, flush, lk_valid, fill_valid, fill_wen;
   logic [31:0] lk_addr;
   logic [1:0] lk_kind, miss_kind;
   logic lk_hit, lk_fault, lk_miss, lk_ref, lk_dirty;
   logic [31:0] lk_paddr;
   logic [VW-1:0] miss_vpn, fill_vpn;
   logic [PW-1:0] fill_pfn;

   xlat_cache i_xlat_cache (
      .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
      .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_fault(lk_fault),
      .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
      .miss_vpn(miss_vpn), .miss_kind(miss_kind), .fill_valid(fill_valid),
      .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wen(fill_wen));

   // behavioural reference state
   bit          mv [N];
   logic [VW-1:0] mvpn [N];
   logic [PW-1:0] mpfn [N];
   bit          mwe [N], mref [N], mdirty [N];
   int          mptr, mlast;
   bit          mlastv;

   int checks = 0;
   int errors = 0;
   string phase = "reset";
   logic [31:0] lfsr = 32'h1ACE_B00C;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s [%s]: actual %0h expected %0h", tag, phase, got, exp);
      end
   endtask

   function automatic int wrap(input int p);
      return (p == N - 1) ? 0 : p + 1;
   endfunction

   task automatic step(input bit lv, input logic [VW-1:0] vpn, input logic [12:0] off,
                       input logic [1:0] k, input bit fv, input logic [VW-1:0] fvp,
                       input logic [PW-1:0] fp, input bit fw, input bit fl);
      int m, d, slot, rot, cl;
      bit w, e_fault, e_hit, e_miss, clv;
      logic [31:0] e_pa;
      @(negedge clk);
      lk_valid = lv; lk_addr = {vpn, off}; lk_kind = k;
      fill_valid = fv; fill_vpn = fvp; fill_pfn = fp; fill_wen = fw; flush = fl;
      #5;
      m = -1;
      for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) m = i;
      w = (k == 2'b01);
      e_fault = lv && m >= 0 && w && !mwe[m >= 0 ? m : 0];
      e_hit   = lv && m >= 0 && !e_fault;
      e_miss  = lv && m < 0;
      e_pa    = e_hit ? {mpfn[m], off} : 32'h0;
      chk("R1 hit", lk_hit, e_hit);
      chk("R1 paddr", lk_paddr, e_pa);
      chk("R2 miss", lk_miss, e_miss);
      chk("R2 miss_vpn", miss_vpn, e_miss ? vpn : '0);
      chk("R2 miss_kind", miss_kind, e_miss ? k : 2'b00);
      chk("R3 fault", lk_fault, e_fault);
      chk("R4 outcome count", lk_hit + lk_miss + lk_fault, lv ? 1 : 0);
      chk("R5 ref", lk_ref, e_hit ? mref[m] : 1'b0);
      chk("R6 dirty", lk_dirty, e_hit ? mdirty[m] : 1'b0);
      @(posedge clk);
      #1;
      if (fl) begin
         for (int i = 0; i < N; i++) mv[i] = 0;
         mlastv = 0;
      end else begin
         clv = e_hit ? 1'b1 : mlastv;
         cl  = e_hit ? m : mlast;
         slot = -1;
         if (fv) begin
            d = -1;
            for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == fvp) d = i;
            if (d >= 0) slot = d;
            else begin
               for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
               if (slot < 0) begin
                  rot = (clv && cl == mptr) ? wrap(mptr) : mptr;
                  slot = rot;
                  mptr = wrap(rot);
               end
            end
         end
         if (e_hit) begin
            mref[m] = 1;
            if (w) mdirty[m] = 1;
            mlastv = 1;
            mlast = m;
         end
         if (slot >= 0) begin
            mv[slot] = 1; mvpn[slot] = fvp; mpfn[slot] = fp; mwe[slot] = fw;
            mref[slot] = 0; mdirty[slot] = 0;
         end
      end
   endtask

   task automatic look(input logic [VW-1:0] vpn, input logic [12:0] off, input logic [1:0] k);
      step(1, vpn, off, k, 0, '0, '0, 0, 0);
   endtask

   task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] pfn, input bit we);
      step(0, '0, '0, 2'b00, 1, vpn, pfn, we, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; flush = 0; lk_valid = 0; lk_addr = '0; lk_kind = '0;
      fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_wen = 0;
      for (int i = 0; i < N; i++) begin
         mv[i] = 0; mvpn[i] = '0; mpfn[i] = '0; mwe[i] = 0; mref[i] = 0; mdirty[i] = 0;
      end
      mptr = 0; mlast = 0; mlastv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      phase = "R10 empty after reset";
      look(19'h100, 13'h5, 2'b00);
      look(19'h0, 13'h0, 2'b01);

      phase = "R11 fill vs same-cycle lookup";
      step(1, 19'h100, 13'h10, 2'b00, 1, 19'h100, 19'h4000, 1, 0);
      look(19'h100, 13'h10, 2'b00);

      phase = "R7 fill empty slots";
      for (int i = 1; i < N; i++) fill(19'h100 + VW'(i), 19'h4000 + PW'(i * 3), i[0]);

      phase = "R1 offsets";
      look(19'h101, 13'h0, 2'b00);
      look(19'h12F, 13'h1FFF, 2'b10);
      look(19'h11A, 13'h0A5A, 2'b00);
      look(19'h200, 13'h0123, 2'b10);

      phase = "R5 used flag";
      look(19'h104, 13'h4, 2'b00);
      look(19'h104, 13'h8, 2'b00);

      phase = "R6 modified flag";
      look(19'h107, 13'h1, 2'b01);
      look(19'h107, 13'h2, 2'b01);
      look(19'h107, 13'h3, 2'b00);
      look(19'h109, 13'h3, 2'b11);

      phase = "R3 write protection";
      look(19'h106, 13'h40, 2'b01);
      look(19'h106, 13'h40, 2'b10);
      look(19'h106, 13'h40, 2'b01);

      phase = "R7 overwrite duplicate";
      fill(19'h105, 19'h7777, 0);
      look(19'h105, 13'h77, 2'b00);
      look(19'h105, 13'h77, 2'b01);

      phase = "R8 rotating victim";
      step(1, 19'h100, 13'h0, 2'b00, 1, 19'h900, 19'h0900, 1, 0);
      fill(19'h901, 19'h0901, 1);
      look(19'h103, 13'h0, 2'b00);
      fill(19'h902, 19'h0902, 1);
      fill(19'h903, 19'h0903, 1);
      look(19'h106, 13'h0, 2'b10);
      fill(19'h904, 19'h0904, 0);
      for (int i = 0; i < 8; i++) look(19'h100 + VW'(i), 13'h11, 2'b00);
      for (int i = 0; i < 5; i++) look(19'h900 + VW'(i), 13'h22, 2'b00);

      phase = "R9 flush";
      step(1, 19'h101, 13'h0, 2'b00, 1, 19'hA00, 19'h0A00, 1, 1);
      look(19'h101, 13'h0, 2'b00);
      look(19'hA00, 13'h0, 2'b00);
      fill(19'hA01, 19'h0A01, 1);
      look(19'hA01, 13'h9, 2'b01);

      phase = "R2 mixed traffic";
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[0], 19'h300 + VW'(lfsr[6:1]), lfsr[19:7], lfsr[21:20],
              lfsr[22] | lfsr[23], 19'h300 + VW'(lfsr[29:24]), PW'(lfsr[31:13]),
              lfsr[30], lfsr[31:26] == 6'h2A);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule